// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two 16-bit buses, called A and B, and passes data between them without inversion. The width is split into two byte lanes. Each lane has its own controls: an isolate input, a direction input, a capture strobe for each direction and a source select for each direction. A lane can forward live data from one bus to the other. It can also drive the value held in a per-direction storage register, which is loaded from the bus it faces.

The design runs on a single system clock. Each capture strobe is a clock enable that is sampled on the rising edge of that clock. Tri-state pins are not used. Each side instead has a data output vector and one active-high drive-enable per lane. A surrounding pad ring or bus fabric turns these into real bus drivers. Putting the same value on both lanes' controls makes the block behave as one 16-bit transceiver.

Top module: `bidir_reg_xcvr`

## Requirements
- R1: While rst_n is low at a rising clk edge, both storage registers of every lane are cleared to zero. After reset, stored-mode outputs read 0 until a capture occurs.
- R2: When cap_ab[i] is 1 at a rising clk edge, the A-side register of lane i loads a_in[8i+7:8i]. When cap_ab[i] is 0, that register keeps its value.
- R3: When cap_ba[i] is 1 at a rising clk edge, the B-side register of lane i loads b_in[8i+7:8i]. When cap_ba[i] is 0, that register keeps its value.
- R4: A capture takes place whatever the values of iso[i] and dir[i].
- R5: When iso[i] is 1, a_oe[i] and b_oe[i] are both 0, and lane i of a_out and of b_out reads zero.
- R6: When iso[i] is 0, dir[i]=1 sets b_oe[i]=1 and a_oe[i]=0, and dir[i]=0 sets a_oe[i]=1 and b_oe[i]=0. The enables follow the controls in the same cycle.
- R7: When b_oe[i] is 1 and sel_ab[i] is 0, lane i of b_out equals lane i of a_in in the same cycle, without inversion.
- R8: When b_oe[i] is 1 and sel_ab[i] is 1, lane i of b_out equals the lane's A-side register.
- R9: When a_oe[i] is 1, lane i of a_out equals lane i of b_in if sel_ba[i] is 0, and equals the lane's B-side register if sel_ba[i] is 1.
- R10: When a capture happens while that register is being driven out in stored mode, the output shows the newly captured value from the following cycle.
- R11: The two lanes are independent. Controls and captures on one lane never change the registers, enables or outputs of the other lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; captures happen on its rising edge |
| rst_n | input | 1 | Active-low synchronous clear of the storage registers |
| a_in | input | 16 | Data received from the A bus |
| b_in | input | 16 | Data received from the B bus |
| iso | input | 2 | Per-lane isolate; 1 turns off both drivers of the lane |
| dir | input | 2 | Per-lane direction; 1 drives B from A, 0 drives A from B |
| cap_ab | input | 2 | Per-lane capture strobe for the A-side register |
| cap_ba | input | 2 | Per-lane capture strobe for the B-side register |
| sel_ab | input | 2 | Per-lane B-output source; 0 live A data, 1 A-side register |
| sel_ba | input | 2 | Per-lane A-output source; 0 live B data, 1 B-side register |
| a_out | output | 16 | Data to drive onto the A bus; zero on lanes not driving |
| a_oe | output | 2 | Per-lane drive enable for the A bus |
| b_out | output | 16 | Data to drive onto the B bus; zero on lanes not driving |
| b_oe | output | 2 | Per-lane drive enable for the B bus |

## Verification
The main function is driven first with directed patterns, then with random patterns.

The directed patterns do the following:
- Capture into each register while the lane is isolated or facing the opposite way, then read the register back in stored mode. This separates capture that is always enabled from capture gated by the enables.
- Capture while already driving in stored mode. This shows that the register output is seen one cycle late and the live path is not.
- Load different values into the two lanes. This exposes any crossing of controls or data between lanes.

Random cycles then vary all controls, strobes and data on every clock. Each cycle is compared against a behavioural model of both registers per lane, which catches a swapped select, direction or inversion in any combination.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic {
    FLOW_TO_A = 1'b0,
    FLOW_TO_B = 1'b1
  } flow_e;

  // Drive enable for one side of a lane: on only when not isolated and flow points there.
  function automatic logic side_enable(input logic isolate, input logic flow, input flow_e side);
    return !isolate && (flow == logic'(side));
  endfunction

endpackage

// File: rtl/xcvr_lane_reg.sv
module xcvr_lane_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

endmodule

// File: rtl/xcvr_lane_path.sv
module xcvr_lane_path #(
  parameter int W = 8
) (
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  input  logic         use_stored,
  input  logic         en,
  output logic [W-1:0] q
);

  logic [W-1:0] picked;

  always_comb begin
    picked = use_stored ? stored : live;
    q      = en ? picked : '0;
  end

endmodule

// File: rtl/bidir_reg_xcvr.sv
module bidir_reg_xcvr #(
  parameter int LANE_W = 8,
  parameter int LANES  = 2,
  localparam int BUS_W = LANE_W * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] a_in,
  input  logic [BUS_W-1:0] b_in,
  input  logic [LANES-1:0] iso,
  input  logic [LANES-1:0] dir,
  input  logic [LANES-1:0] cap_ab,
  input  logic [LANES-1:0] cap_ba,
  input  logic [LANES-1:0] sel_ab,
  input  logic [LANES-1:0] sel_ba,
  output logic [BUS_W-1:0] a_out,
  output logic [LANES-1:0] a_oe,
  output logic [BUS_W-1:0] b_out,
  output logic [LANES-1:0] b_oe
);
  import xcvr_pkg::*;

  // Register contents brought out as named wires for the checker.
  logic [BUS_W-1:0] a_store;
  logic [BUS_W-1:0] b_store;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int LO = g * LANE_W;

    xcvr_lane_reg #(.W(LANE_W)) u_areg (
      .clk(clk), .rst_n(rst_n), .load(cap_ab[g]),
      .d(a_in[LO +: LANE_W]), .q(a_store[LO +: LANE_W])
    );

    xcvr_lane_reg #(.W(LANE_W)) u_breg (
      .clk(clk), .rst_n(rst_n), .load(cap_ba[g]),
      .d(b_in[LO +: LANE_W]), .q(b_store[LO +: LANE_W])
    );

    always_comb begin
      b_oe[g] = side_enable(iso[g], dir[g], FLOW_TO_B);
      a_oe[g] = side_enable(iso[g], dir[g], FLOW_TO_A);
    end

    xcvr_lane_path #(.W(LANE_W)) u_to_b (
      .live(a_in[LO +: LANE_W]), .stored(a_store[LO +: LANE_W]),
      .use_stored(sel_ab[g]), .en(b_oe[g]), .q(b_out[LO +: LANE_W])
    );

    xcvr_lane_path #(.W(LANE_W)) u_to_a (
      .live(b_in[LO +: LANE_W]), .stored(b_store[LO +: LANE_W]),
      .use_stored(sel_ba[g]), .en(a_oe[g]), .q(a_out[LO +: LANE_W])
    );
  end

endmodule

// File: rtl/bidir_reg_xcvr_chk.sv
module bidir_reg_xcvr_chk #(
  parameter int LANE_W = 8,
  parameter int LANES  = 2,
  localparam int BUS_W = LANE_W * LANES
) (
  input logic             clk,
  input logic             rst_n,
  input logic [BUS_W-1:0] a_in,
  input logic [BUS_W-1:0] b_in,
  input logic [LANES-1:0] iso,
  input logic [LANES-1:0] dir,
  input logic [LANES-1:0] cap_ab,
  input logic [LANES-1:0] cap_ba,
  input logic [LANES-1:0] sel_ab,
  input logic [LANES-1:0] sel_ba,
  input logic [BUS_W-1:0] a_out,
  input logic [LANES-1:0] a_oe,
  input logic [BUS_W-1:0] b_out,
  input logic [LANES-1:0] b_oe,
  input logic [BUS_W-1:0] a_store,
  input logic [BUS_W-1:0] b_store
);

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    localparam int LO = g * LANE_W;

    assert_load_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cap_ab[g] |=> a_store[LO +: LANE_W] == $past(a_in[LO +: LANE_W]));

    assert_keep_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_ab[g] |=> $stable(a_store[LO +: LANE_W]));

    assert_load_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cap_ba[g] |=> b_store[LO +: LANE_W] == $past(b_in[LO +: LANE_W]));

    assert_keep_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_ba[g] |=> $stable(b_store[LO +: LANE_W]));

    assert_isolate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      iso[g] |-> (!a_oe[g] && !b_oe[g] && a_out[LO +: LANE_W] == '0 && b_out[LO +: LANE_W] == '0));

    assert_one_side_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !iso[g] |-> ($countones({a_oe[g], b_oe[g]}) == 1 && b_oe[g] == dir[g]));

    assert_live_to_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (b_oe[g] && !sel_ab[g]) |-> b_out[LO +: LANE_W] == a_in[LO +: LANE_W]);

    assert_store_to_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (b_oe[g] && sel_ab[g]) |-> b_out[LO +: LANE_W] == a_store[LO +: LANE_W]);

    assert_live_to_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (a_oe[g] && !sel_ba[g]) |-> a_out[LO +: LANE_W] == b_in[LO +: LANE_W]);

    assert_store_to_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (a_oe[g] && sel_ba[g]) |-> a_out[LO +: LANE_W] == b_store[LO +: LANE_W]);

    assert_update_b_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cap_ab[g] ##1 (b_oe[g] && sel_ab[g]) |-> b_out[LO +: LANE_W] == $past(a_in[LO +: LANE_W]));
  end

endmodule

bind bidir_reg_xcvr bidir_reg_xcvr_chk #(.LANE_W(LANE_W), .LANES(LANES)) chk_i (.*);

// File: tb/bidir_reg_xcvr_tb_top.sv
module bidir_reg_xcvr_tb_top;

  localparam int LW = 8;
  localparam int NL = 2;
  localparam int BW = LW * NL;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [BW-1:0] a_in = '0, b_in = '0;
  logic [NL-1:0] iso = '1, dir = '0, cap_ab = '0, cap_ba = '0, sel_ab = '0, sel_ba = '0;
  logic [BW-1:0] a_out, b_out;
  logic [NL-1:0] a_oe, b_oe;

  int checks = 0;
  int failures = 0;
  int ra[NL];
  int rb[NL];

  always #5 clk = ~clk;

  bidir_reg_xcvr #(.LANE_W(LW), .LANES(NL)) dut_i (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .iso(iso), .dir(dir),
    .cap_ab(cap_ab), .cap_ba(cap_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
  );

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0h expected=%0h", tag, got, exp);
    end
  endtask

  // Compare all outputs against the model, then advance one clock updating the model.
  task automatic step(input string tag);
    #1;
    for (int l = 0; l < NL; l++) begin
      int ain = int'(a_in[l*LW +: LW]);
      int bin = int'(b_in[l*LW +: LW]);
      bit eb = !iso[l] && dir[l];
      bit ea = !iso[l] && !dir[l];
      int xb = eb ? (sel_ab[l] ? ra[l] : ain) : 0;
      int xa = ea ? (sel_ba[l] ? rb[l] : bin) : 0;
      check(tag, {a_oe[l], b_oe[l]}, {ea, eb});
      check(tag, int'(b_out[l*LW +: LW]), xb);
      check(tag, int'(a_out[l*LW +: LW]), xa);
    end
    @(posedge clk);
    for (int l = 0; l < NL; l++) begin
      if (!rst_n) begin
        ra[l] = 0;
        rb[l] = 0;
      end else begin
        if (cap_ab[l]) ra[l] = int'(a_in[l*LW +: LW]);
        if (cap_ba[l]) rb[l] = int'(b_in[l*LW +: LW]);
      end
    end
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int l = 0; l < NL; l++) begin
      ra[l] = 0;
      rb[l] = 0;
    end
    @(negedge clk);
    step("R5_reset");
    step("R5_reset");
    rst_n = 1'b1;
    // R1: stored mode right after reset reads zero, both directions
    iso = '0; dir = '1; sel_ab = '1; a_in = 16'hFFFF;
    step("R1_stored_b");
    dir = '0; sel_ba = '1; b_in = 16'hFFFF;
    step("R1_stored_a");
    // R4: capture while isolated, then R2 read back
    iso = '1; a_in = 16'hA55A; cap_ab = '1;
    step("R4_iso_cap");
    cap_ab = '0; a_in = 16'h0000; iso = '0; dir = '1; sel_ab = '1;
    step("R2_readback");
    // R4: capture B while driving toward B, then R3 read back
    b_in = 16'h3CC3; cap_ba = '1;
    step("R4_dir_cap");
    cap_ba = '0; b_in = 16'h0000; dir = '0; sel_ba = '1;
    step("R3_readback");
    // R7 / R9 transparent, non-inverting
    dir = '1; sel_ab = '0; a_in = 16'h1E87;
    step("R7_live");
    dir = '0; sel_ba = '0; b_in = 16'hF00D;
    step("R9_live");
    // R10: capture while driven in stored mode
    dir = '1; sel_ab = '1; a_in = 16'h6699; cap_ab = '1;
    step("R10_cap");
    cap_ab = '0; a_in = 16'h0101;
    step("R10_next");
    // R11: lane 0 only
    cap_ab = 2'b01; a_in = 16'h7722;
    step("R11_lane0");
    cap_ab = '0; iso = 2'b10; dir = 2'b01; sel_ab = 2'b11;
    step("R11_split");
    // R6 / R8 / R9 random
    for (int n = 0; n < 3000; n++) begin
      a_in = 16'($urandom); b_in = 16'($urandom);
      iso = 2'($urandom); dir = 2'($urandom);
      cap_ab = 2'($urandom); cap_ba = 2'($urandom);
      sel_ab = 2'($urandom); sel_ba = 2'($urandom);
      step("R6_R8_R9_rand");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule